// File: doc/BRIEF.md
# Dual-Source Waveform Parameter Arbiter

This block sits between two producers of waveform settings and the consumers that act on them. One producer is the local panel, whose switches, buttons and knob give a waveform kind, a frequency split into three digit counters and an amplitude factor. The other is a host link that delivers the same set after a complete message has been received. Each producer marks a fresh setting with a one-cycle change strobe. The arbiter forwards one of the two sets as the active set for the tone generator and the display.

The most recent producer to strobe owns the active set and keeps it while both are quiet. The active fields then follow that producer's present inputs. A host update is copied back to the panel's frequency counters through a one-cycle load strobe, so later button steps continue from the host value. Kind and amplitude are never copied back, because the panel reads them from switches and a knob. A panel update raises a one-cycle transmit request so that the host view stays in step. A registered band decoder enables the buzzer while the active frequency is inside the audible band.

Top module: `wave_param_arbiter`

## Requirements
- R1: In a cycle where `host_chg` is high, all active fields equal the host inputs in that same cycle and `act_from_host` is 1. Kind codes pass through unchanged: 2'b00 sine, 2'b01 triangle, 2'b10 square.
- R2: In a cycle where `brd_chg` is high and `host_chg` is low, all active fields equal the panel inputs in that same cycle and `act_from_host` is 0.
- R3: In a cycle with neither strobe, the owner is the source that strobed most recently. The active fields equal that owner's present inputs, so changes on the other source's inputs have no effect on them.
- R4: When both strobes are high in one cycle, the host wins (R1 applies). In the next cycle `wb_load` is 1 and `tx_req` is 0.
- R5: `tx_req` is 1 for exactly the cycle after a cycle with `brd_chg` high and `host_chg` low, and is 0 at all other times.
- R6: `wb_load` is 1 for exactly the cycle after a cycle with `host_chg` high, and is 0 at all other times. While `wb_load` is 1, `wb_tens`, `wb_k` and `wb_tenk` carry the host frequency digits seen in the strobe cycle.
- R7: `buzz_en` in cycle N+1 is 1 exactly when, in cycle N, tens×10 + k×1000 + tenk×10000 of the active frequency lies from 1000 to 10000 inclusive.
- R8: While `rst_n` is low, and in the first cycle after it rises, the panel is the owner and `tx_req`, `wb_load` and `buzz_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brd_kind | input | 2 | Panel waveform kind |
| brd_tens | input | 7 | Panel tens-of-Hz counter (0..99) |
| brd_k | input | 4 | Panel kHz counter (0..9) |
| brd_tenk | input | 5 | Panel tens-of-kHz counter (0..20) |
| brd_amp | input | 8 | Panel amplitude factor |
| brd_chg | input | 1 | Panel change strobe |
| host_kind | input | 2 | Host waveform kind |
| host_tens | input | 7 | Host tens-of-Hz digit group |
| host_k | input | 4 | Host kHz digit |
| host_tenk | input | 5 | Host tens-of-kHz digit group |
| host_amp | input | 8 | Host amplitude factor |
| host_chg | input | 1 | Host message-complete strobe |
| act_kind | output | 2 | Active waveform kind |
| act_tens | output | 7 | Active tens-of-Hz counter |
| act_k | output | 4 | Active kHz counter |
| act_tenk | output | 5 | Active tens-of-kHz counter |
| act_amp | output | 8 | Active amplitude factor |
| act_from_host | output | 1 | 1 when the host set is active |
| tx_req | output | 1 | One-cycle request to send panel settings to the host |
| wb_load | output | 1 | One-cycle load strobe for the panel frequency counters |
| wb_tens | output | 7 | Tens-of-Hz value to load into the panel |
| wb_k | output | 4 | kHz value to load into the panel |
| wb_tenk | output | 5 | Tens-of-kHz value to load into the panel |
| buzz_en | output | 1 | Buzzer enable, active frequency in band |

## Verification
The assertions assume that both strobes are low while reset is held, and that frequency digits stay within their legal ranges of 0..99, 0..9 and 0..20. Under that assumption the band sum cannot wrap. The stimulus drives every input just after a rising edge and never raises a strobe during reset. It draws random digits only from those ranges and biases the tens-of-kHz digit towards small values, so that the band edges at 990, 1000, 10000 and 10010 Hz are reached, together with directed visits. Strobe timing is random, with no spacing rule. This covers back-to-back strobes, simultaneous strobes and long idle stretches, during which the inputs of the source that is not the owner keep changing.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
   localparam int unsigned TENS_STEP_HZ = 10;
   localparam int unsigned K_STEP_HZ    = 1000;
   localparam int unsigned TENK_STEP_HZ = 10000;

   // largest frequency any digit combination of the given widths can form
   function automatic int unsigned max_hz(input int unsigned tens_w,
                                          input int unsigned k_w,
                                          input int unsigned tenk_w);
      return ((2**tens_w) - 1) * TENS_STEP_HZ
           + ((2**k_w)    - 1) * K_STEP_HZ
           + ((2**tenk_w) - 1) * TENK_STEP_HZ;
   endfunction
endpackage

// File: rtl/wpa_src_select.sv
module wpa_src_select (
   input  logic clk,
   input  logic rst_n,
   input  logic host_chg,
   input  logic brd_chg,
   output logic use_host
);
   logic owner_host_q;

   // a strobe overrides the stored owner in its own cycle; host wins ties
   always_comb use_host = host_chg | (~brd_chg & owner_host_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_host_q <= 1'b0;
      else        owner_host_q <= use_host;
   end
endmodule

// File: rtl/wpa_field_mux.sv
module wpa_field_mux #(
   parameter int unsigned W = 8
) (
   input  logic         use_host,
   input  logic [W-1:0] brd_val,
   input  logic [W-1:0] host_val,
   output logic [W-1:0] act_val
);
   initial assert (W >= 1) else $error("wpa_field_mux: W must be at least 1");

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign act_val[b] = use_host ? host_val[b] : brd_val[b];
   end
endmodule

// File: rtl/wpa_link_events.sv
module wpa_link_events #(
   parameter int unsigned TENS_W = 7,
   parameter int unsigned K_W    = 4,
   parameter int unsigned TENK_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_chg,
   input  logic              brd_chg,
   input  logic [TENS_W-1:0] host_tens,
   input  logic [K_W-1:0]    host_k,
   input  logic [TENK_W-1:0] host_tenk,
   output logic              tx_req,
   output logic              wb_load,
   output logic [TENS_W-1:0] wb_tens,
   output logic [K_W-1:0]    wb_k,
   output logic [TENK_W-1:0] wb_tenk
);
   // transmit only for a panel change the host did not override
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_req  <= 1'b0;
         wb_load <= 1'b0;
      end else begin
         tx_req  <= brd_chg & ~host_chg;
         wb_load <= host_chg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_tens <= '0;
         wb_k    <= '0;
         wb_tenk <= '0;
      end else if (host_chg) begin
         wb_tens <= host_tens;
         wb_k    <= host_k;
         wb_tenk <= host_tenk;
      end
   end
endmodule

// File: rtl/wpa_band_decode.sv
module wpa_band_decode #(
   parameter int unsigned TENS_W = 7,
   parameter int unsigned K_W    = 4,
   parameter int unsigned TENK_W = 5,
   parameter int unsigned LO_HZ  = 1000,
   parameter int unsigned HI_HZ  = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TENS_W-1:0] tens,
   input  logic [K_W-1:0]    k,
   input  logic [TENK_W-1:0] tenk,
   output logic              in_band
);
   import wpa_pkg::*;

   localparam int unsigned TOP_HZ = (max_hz(TENS_W, K_W, TENK_W) > HI_HZ) ?
                                    max_hz(TENS_W, K_W, TENK_W) : HI_HZ;
   localparam int unsigned HZ_W   = $clog2(TOP_HZ + 1);

   initial assert (LO_HZ <= HI_HZ) else $error("wpa_band_decode: LO_HZ above HI_HZ");

   logic [HZ_W-1:0] hz;

   always_comb begin
      hz = HZ_W'(tens) * HZ_W'(TENS_STEP_HZ)
         + HZ_W'(k)    * HZ_W'(K_STEP_HZ)
         + HZ_W'(tenk) * HZ_W'(TENK_STEP_HZ);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_band <= 1'b0;
      else        in_band <= (hz >= HZ_W'(LO_HZ)) && (hz <= HZ_W'(HI_HZ));
   end
endmodule

// File: rtl/wave_param_arbiter.sv
module wave_param_arbiter #(
   parameter int unsigned KIND_W = 2,
   parameter int unsigned TENS_W = 7,
   parameter int unsigned K_W    = 4,
   parameter int unsigned TENK_W = 5,
   parameter int unsigned AMP_W  = 8,
   parameter int unsigned LO_HZ  = 1000,
   parameter int unsigned HI_HZ  = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KIND_W-1:0] brd_kind,
   input  logic [TENS_W-1:0] brd_tens,
   input  logic [K_W-1:0]    brd_k,
   input  logic [TENK_W-1:0] brd_tenk,
   input  logic [AMP_W-1:0]  brd_amp,
   input  logic              brd_chg,
   input  logic [KIND_W-1:0] host_kind,
   input  logic [TENS_W-1:0] host_tens,
   input  logic [K_W-1:0]    host_k,
   input  logic [TENK_W-1:0] host_tenk,
   input  logic [AMP_W-1:0]  host_amp,
   input  logic              host_chg,
   output logic [KIND_W-1:0] act_kind,
   output logic [TENS_W-1:0] act_tens,
   output logic [K_W-1:0]    act_k,
   output logic [TENK_W-1:0] act_tenk,
   output logic [AMP_W-1:0]  act_amp,
   output logic              act_from_host,
   output logic              tx_req,
   output logic              wb_load,
   output logic [TENS_W-1:0] wb_tens,
   output logic [K_W-1:0]    wb_k,
   output logic [TENK_W-1:0] wb_tenk,
   output logic              buzz_en
);
   localparam int unsigned NFIELD = 5;
   localparam int unsigned FW [NFIELD] = '{KIND_W, TENS_W, K_W, TENK_W, AMP_W};
   localparam int unsigned SET_W = KIND_W + TENS_W + K_W + TENK_W + AMP_W;

   initial assert (KIND_W >= 2) else $error("KIND_W too narrow for three kinds");
   initial assert (TENS_W >= $clog2(100)) else $error("TENS_W cannot hold 99");
   initial assert (K_W >= $clog2(10)) else $error("K_W cannot hold 9");
   initial assert (TENK_W >= $clog2(21)) else $error("TENK_W cannot hold 20");
   initial assert (AMP_W >= 1) else $error("AMP_W must be at least 1");

   logic             use_host;
   logic [SET_W-1:0] brd_set, host_set, act_set;

   assign brd_set  = {brd_kind, brd_tens, brd_k, brd_tenk, brd_amp};
   assign host_set = {host_kind, host_tens, host_k, host_tenk, host_amp};
   assign {act_kind, act_tens, act_k, act_tenk, act_amp} = act_set;
   assign act_from_host = use_host;

   wpa_src_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_chg (host_chg),
      .brd_chg  (brd_chg),
      .use_host (use_host)
   );

   // one multiplexer per field, each at its own offset in the packed set
   for (genvar f = 0; f < NFIELD; f++) begin : g_field
      localparam int unsigned LSB = (f == 0) ? SET_W - FW[0]
                                 : (f == 1) ? SET_W - FW[0] - FW[1]
                                 : (f == 2) ? SET_W - FW[0] - FW[1] - FW[2]
                                 : (f == 3) ? FW[4]
                                 : 0;
      wpa_field_mux #(.W(FW[f])) u_mux (
         .use_host (use_host),
         .brd_val  (brd_set[LSB +: FW[f]]),
         .host_val (host_set[LSB +: FW[f]]),
         .act_val  (act_set[LSB +: FW[f]])
      );
   end

   wpa_link_events #(.TENS_W(TENS_W), .K_W(K_W), .TENK_W(TENK_W)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_chg  (host_chg),
      .brd_chg   (brd_chg),
      .host_tens (host_tens),
      .host_k    (host_k),
      .host_tenk (host_tenk),
      .tx_req    (tx_req),
      .wb_load   (wb_load),
      .wb_tens   (wb_tens),
      .wb_k      (wb_k),
      .wb_tenk   (wb_tenk)
   );

   wpa_band_decode #(.TENS_W(TENS_W), .K_W(K_W), .TENK_W(TENK_W),
                     .LO_HZ(LO_HZ), .HI_HZ(HI_HZ)) u_band (
      .clk     (clk),
      .rst_n   (rst_n),
      .tens    (act_tens),
      .k       (act_k),
      .tenk    (act_tenk),
      .in_band (buzz_en)
   );
endmodule

// File: rtl/wpa_checker.sv
module wpa_checker #(
   parameter int unsigned TENS_W = 7,
   parameter int unsigned K_W    = 4,
   parameter int unsigned TENK_W = 5,
   parameter int unsigned LO_HZ  = 1000,
   parameter int unsigned HI_HZ  = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              brd_chg,
   input logic              host_chg,
   input logic [TENS_W-1:0] host_tens,
   input logic [TENS_W-1:0] act_tens,
   input logic [K_W-1:0]    act_k,
   input logic [TENK_W-1:0] act_tenk,
   input logic              act_from_host,
   input logic              tx_req,
   input logic              wb_load,
   input logic [TENS_W-1:0] wb_tens,
   input logic              buzz_en
);
   logic        past_ok;
   int unsigned hz_seen;
   logic        band_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_comb begin
      hz_seen   = int'(act_tens) * 10 + int'(act_k) * 1000 + int'(act_tenk) * 10000;
      band_seen = (hz_seen >= LO_HZ) && (hz_seen <= HI_HZ);
   end

   // R1
   host_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_chg |-> act_from_host);
   // R2
   brd_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brd_chg && !host_chg) |-> !act_from_host);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !brd_chg && !host_chg) |-> (act_from_host == $past(act_from_host)));
   // R4
   tie_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_req && wb_load));
   // R5
   tx_after_brd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brd_chg && !host_chg) |=> tx_req);
   // R5
   tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && tx_req) |-> $past(brd_chg && !host_chg));
   // R6
   wb_after_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_chg |=> (wb_load && wb_tens == $past(host_tens)));
   // R6
   wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && wb_load) |-> $past(host_chg));
   // R7
   band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (buzz_en == $past(band_seen)));
   // R8
   first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !past_ok |-> (!tx_req && !wb_load && !buzz_en));
endmodule

bind wave_param_arbiter wpa_checker #(
   .TENS_W(TENS_W), .K_W(K_W), .TENK_W(TENK_W), .LO_HZ(LO_HZ), .HI_HZ(HI_HZ)
) u_wpa_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .brd_chg       (brd_chg),
   .host_chg      (host_chg),
   .host_tens     (host_tens),
   .act_tens      (act_tens),
   .act_k         (act_k),
   .act_tenk      (act_tenk),
   .act_from_host (act_from_host),
   .tx_req        (tx_req),
   .wb_load       (wb_load),
   .wb_tens       (wb_tens),
   .buzz_en       (buzz_en)
);

// File: tb/wave_param_arbiter_bench.sv
`timescale 1ns/1ps
module wave_param_arbiter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] brd_kind = 0, host_kind = 0;
   logic [6:0] brd_tens = 7'd10, host_tens = 0;
   logic [3:0] brd_k = 0, host_k = 0;
   logic [4:0] brd_tenk = 0, host_tenk = 0;
   logic [7:0] brd_amp = 0, host_amp = 0;
   logic       brd_chg = 0, host_chg = 0;
   logic [1:0] act_kind;
   logic [6:0] act_tens, wb_tens;
   logic [3:0] act_k, wb_k;
   logic [4:0] act_tenk, wb_tenk;
   logic [7:0] act_amp;
   logic       act_from_host, tx_req, wb_load, buzz_en;

   int checks = 0, failures = 0;
   bit done = 0;

   // reference model state
   int m_owner_host = 0, m_tx = 0, m_wb = 0, m_buzz = 0;
   int m_wb_tens = 0, m_wb_k = 0, m_wb_tenk = 0;
   int m_first = 1;

   always #5 clk = ~clk;

   wave_param_arbiter u_wave_param_arbiter (
      .clk(clk), .rst_n(rst_n),
      .brd_kind(brd_kind), .brd_tens(brd_tens), .brd_k(brd_k), .brd_tenk(brd_tenk),
      .brd_amp(brd_amp), .brd_chg(brd_chg),
      .host_kind(host_kind), .host_tens(host_tens), .host_k(host_k),
      .host_tenk(host_tenk), .host_amp(host_amp), .host_chg(host_chg),
      .act_kind(act_kind), .act_tens(act_tens), .act_k(act_k), .act_tenk(act_tenk),
      .act_amp(act_amp), .act_from_host(act_from_host), .tx_req(tx_req),
      .wb_load(wb_load), .wb_tens(wb_tens), .wb_k(wb_k), .wb_tenk(wb_tenk),
      .buzz_en(buzz_en));

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int hz_of(input int t, input int k, input int tk);
      return t * 10 + k * 1000 + tk * 10000;
   endfunction

   function automatic int owner_now();
      if (host_chg) return 1;
      if (brd_chg) return 0;
      return m_owner_host;
   endfunction

   // model update on each rising edge (inputs are stable here)
   always @(posedge clk) begin
      if (!rst_n) begin
         m_owner_host = 0; m_tx = 0; m_wb = 0; m_buzz = 0; m_first = 1;
      end else begin
         int o, hz;
         o = owner_now();
         hz = o ? hz_of(host_tens, host_k, host_tenk) : hz_of(brd_tens, brd_k, brd_tenk);
         m_buzz = (hz >= 1000 && hz <= 10000) ? 1 : 0;
         m_tx = (brd_chg && !host_chg) ? 1 : 0;
         m_wb = host_chg ? 1 : 0;
         if (host_chg) begin
            m_wb_tens = host_tens; m_wb_k = host_k; m_wb_tenk = host_tenk;
         end
         m_owner_host = o;
         m_first = 0;
      end
   end

   // compare on each falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         check("R8", "reset act_from_host", act_from_host, brd_chg ? 0 : host_chg);
         check("R8", "reset tx_req", tx_req, 0);
         check("R8", "reset wb_load", wb_load, 0);
         check("R8", "reset buzz_en", buzz_en, 0);
      end else begin
         string tag;
         int o;
         o = owner_now();
         if (host_chg && brd_chg) tag = "R4";
         else if (host_chg)       tag = "R1";
         else if (brd_chg)        tag = "R2";
         else                     tag = "R3";
         check(tag, "act_from_host", act_from_host, o);
         check(tag, "act_kind", act_kind, o ? host_kind : brd_kind);
         check(tag, "act_tens", act_tens, o ? host_tens : brd_tens);
         check(tag, "act_k", act_k, o ? host_k : brd_k);
         check(tag, "act_tenk", act_tenk, o ? host_tenk : brd_tenk);
         check(tag, "act_amp", act_amp, o ? host_amp : brd_amp);
         check(m_first ? "R8" : "R5", "tx_req", tx_req, m_tx);
         check(m_first ? "R8" : "R6", "wb_load", wb_load, m_wb);
         if (m_wb) begin
            check("R6", "wb_tens", wb_tens, m_wb_tens);
            check("R6", "wb_k", wb_k, m_wb_k);
            check("R6", "wb_tenk", wb_tenk, m_wb_tenk);
         end
         check(m_first ? "R8" : "R7", "buzz_en", buzz_en, m_buzz);
      end
   end

   task automatic step();
      @(posedge clk); #1;
      brd_chg = 0; host_chg = 0;
   endtask

   task automatic brd_set(input int kd, input int t, input int k, input int tk, input int a);
      @(posedge clk); #1;
      brd_kind = 2'(kd); brd_tens = 7'(t); brd_k = 4'(k); brd_tenk = 5'(tk);
      brd_amp = 8'(a); brd_chg = 1; host_chg = 0;
      step();
   endtask

   task automatic host_set(input int kd, input int t, input int k, input int tk, input int a);
      @(posedge clk); #1;
      host_kind = 2'(kd); host_tens = 7'(t); host_k = 4'(k); host_tenk = 5'(tk);
      host_amp = 8'(a); host_chg = 1; brd_chg = 0;
      step();
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      repeat (3) step();
      // R2/R5: panel change, kind triangle
      brd_set(1, 50, 2, 0, 77);
      // R3: host inputs move with no strobe, panel stays owner
      @(posedge clk); #1 host_tens = 7'd33; host_kind = 2'd2; host_amp = 8'd200;
      repeat (3) step();
      // R1/R6: host message, square at 10 kHz
      host_set(2, 0, 0, 1, 150);
      // R3: panel inputs move with no strobe, host stays owner
      @(posedge clk); #1 brd_tens = 7'd99; brd_k = 4'd9; brd_amp = 8'd5;
      repeat (3) step();
      // R4: simultaneous strobes
      @(posedge clk); #1;
      brd_kind = 0; brd_tens = 7'd20; brd_chg = 1;
      host_kind = 1; host_tens = 7'd40; host_k = 4'd3; host_chg = 1;
      step(); step();
      // R7: band edges via the panel
      brd_set(0, 99, 0, 0, 1);    // 990 Hz, out
      brd_set(0, 0, 1, 0, 1);     // 1000 Hz, in
      brd_set(0, 99, 9, 0, 1);    // 9990 Hz, in
      brd_set(0, 0, 0, 1, 1);     // 10000 Hz, in
      brd_set(0, 1, 0, 1, 1);     // 10010 Hz, out
      brd_set(0, 0, 0, 20, 1);    // 200000 Hz, out
      brd_set(0, 10, 0, 0, 1);    // 100 Hz, out
      // back-to-back strobes from alternating sources
      host_set(0, 0, 5, 0, 9);
      brd_set(2, 0, 2, 0, 9);
      host_set(1, 0, 0, 1, 9);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         @(posedge clk); #1;
         brd_chg = ($urandom_range(0, 7) == 0);
         host_chg = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 3) == 0) begin
            brd_kind = 2'($urandom_range(0, 2)); brd_tens = 7'($urandom_range(0, 99));
            brd_k = 4'($urandom_range(0, 9));
            brd_tenk = 5'($urandom_range(0, 1) ? $urandom_range(0, 1) : $urandom_range(0, 20));
            brd_amp = 8'($urandom_range(0, 255));
         end
         if ($urandom_range(0, 3) == 0) begin
            host_kind = 2'($urandom_range(0, 2)); host_tens = 7'($urandom_range(0, 99));
            host_k = 4'($urandom_range(0, 9));
            host_tenk = 5'($urandom_range(0, 1) ? $urandom_range(0, 1) : $urandom_range(0, 20));
            host_amp = 8'($urandom_range(0, 255));
         end
      end
      step(); step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule